// File: doc/BRIEF.md
# Ethernet receive destination address filter

This block sits on the receive path of an Ethernet MAC and decides, for every incoming frame, whether it is kept or dropped. Frame bytes arrive one per cycle while `rx_valid` is high, and `rx_sof` marks the first byte. The filter looks only at the first six bytes, which form the destination address. It compares them with a programmed station address. Group addresses are checked against a hash table. The table is indexed by a CRC-32 computed over the address, and the CRC advances one byte per accepted byte. A single-cycle pulse on `dec_valid`, together with `dec_accept`, reports the verdict.

A narrow write port programs the station address, a three-bit control word and the hash words. Any write is staged, and the filter copies it into its active copy only on the first byte of a frame. A frame already in flight therefore keeps the settings it started with. The parameter `WIDE_HASH` selects a 64-entry table (two 32-bit words) or a 256-entry table (eight words).

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, and until a sixth address byte has been received, `dec_valid` and `dec_accept` stay low; all configuration registers reset to zero.
- R2: `dec_valid` pulses for exactly one cycle, in the cycle after the sixth destination byte is taken. Bytes after the sixth byte produce no further decision until the next `rx_sof`.
- R3: An individual address (bit 0 of destination byte 0 clear) is accepted only when all 48 bits equal the station address. Destination byte k occupies bits 8k+7:8k. The station address is written as two registers. Select 0 holds bytes 0 to 3, with byte 0 in bits 7:0. Select 1 holds bytes 4 and 5 in bits 15:0.
- R4: The all-ones broadcast address is accepted whatever the control word holds.
- R5: Control bit 0 (select 2), the promiscuous bit, accepts every frame.
- R6: Control bit 1, pass-all-group, accepts every address whose bit 0 of byte 0 is set. It does not open the filter to non-matching individual addresses.
- R7: Control bit 2 enables the hash lookup for group addresses. The index is computed as follows:
  - Run a reflected CRC-32 (polynomial 0xEDB88320, seed all ones) over the six address bytes, each byte least significant bit first.
  - Complement the low byte of the result and bit-reverse it.
  - In 64-entry mode, keep only its upper 6 bits. In 256-entry mode, keep all 8 bits.
  - Hash word number index>>5 sits at select 8+word. Within that word, bit index&31 admits the address.
  - The lookup never admits an individual address.
- R8: A group address that is not broadcast and is not the station address is dropped when control bits 1 and 2 are both clear.
- R9: The configuration is sampled on the cycle that takes byte 0. A write made on that cycle or later in the frame does not change that frame's decision, and it applies from the next frame on.
- R10: An `rx_sof` during an unfinished address restarts capture, with that byte as byte 0. The abandoned address yields no decision.
- R11: Cycles with `rx_valid` low inside the address pause capture and the CRC without changing the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 4 | Register select: 0 station low, 1 station high, 2 control, 8+k hash word k |
| cfg_wdata | input | 32 | Register write data |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | First byte of a frame |
| rx_byte | input | 8 | Receive byte |
| dec_valid | output | 1 | Decision strobe, one cycle |
| dec_accept | output | 1 | Frame accepted (meaningful with `dec_valid`) |

## Verification
The hardest case to reach from the ports is a hash hit. The bit that admits a group address depends on a CRC of that address, so a test that sets a fixed bit tends to hit an empty slot. The bench carries its own bit-serial CRC model and derives the index of a chosen group address from it. It then sets exactly that bit and expects acceptance, and it checks that a table full of ones still rejects individual addresses. The second hard case is a write that lands in the middle of an address. The driver writes the control word during byte 3 and scores that frame against the settings in force at its first byte.

// File: rtl/raf_pkg.sv
package raf_pkg;
  localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;
  localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;
  localparam int          ADDR_BYTES = 6;

  localparam logic [3:0] SEL_STA_LO    = 4'd0;
  localparam logic [3:0] SEL_STA_HI    = 4'd1;
  localparam logic [3:0] SEL_CTRL      = 4'd2;
  localparam logic [3:0] SEL_HASH_BASE = 4'd8;

  typedef struct packed {
    logic hash_en;   // bit 2
    logic all_grp;   // bit 1
    logic promisc;   // bit 0
  } raf_ctrl_t;

  // one byte of a reflected CRC-32, data LSB first
  function automatic logic [31:0] crc_step_byte(input logic [31:0] c_in, input logic [7:0] d);
    logic [31:0] c;
    c = c_in ^ {24'd0, d};
    for (int i = 0; i < 8; i++) c = c[0] ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
    return c;
  endfunction

  function automatic logic [7:0] rev8(input logic [7:0] x);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = x[7-i];
    return r;
  endfunction

  // table index from the final CRC state
  function automatic logic [7:0] hash_index(input logic [31:0] crc, input bit wide);
    logic [7:0] r;
    r = rev8(~crc[7:0]);
    return wide ? r : {2'b00, r[7:2]};
  endfunction
endpackage

// File: rtl/raf_cfg_regs.sv
module raf_cfg_regs
  import raf_pkg::*;
#(
  parameter int NWORDS = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [3:0]             wr_sel,
  input  logic [31:0]            wr_data,
  input  logic                   snap,
  output logic [47:0]            act_station,
  output raf_ctrl_t              act_ctrl,
  output logic [NWORDS*32-1:0]   act_hash
);
  localparam int HBITS = NWORDS * 32;

  logic [31:0]      sta_lo_q;
  logic [15:0]      sta_hi_q;
  raf_ctrl_t        ctrl_q;
  logic [HBITS-1:0] hash_q;

  // staged (software-visible) copy
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sta_lo_q <= '0;
      sta_hi_q <= '0;
      ctrl_q   <= '0;
      hash_q   <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_STA_LO: sta_lo_q <= wr_data;
        SEL_STA_HI: sta_hi_q <= wr_data[15:0];
        SEL_CTRL:   ctrl_q   <= raf_ctrl_t'(wr_data[2:0]);
        default: begin
          for (int k = 0; k < NWORDS; k++)
            if (wr_sel == SEL_HASH_BASE + 4'(k)) hash_q[k*32 +: 32] <= wr_data;
        end
      endcase
    end
  end

  // active copy, refreshed only when a frame begins
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_station <= '0;
      act_ctrl    <= '0;
      act_hash    <= '0;
    end else if (snap) begin
      act_station <= {sta_hi_q, sta_lo_q};
      act_ctrl    <= ctrl_q;
      act_hash    <= hash_q;
    end
  end

  property p_cfg_held;
    @(posedge clk) disable iff (!rst_n)
      !snap |=> ($stable(act_ctrl) && $stable(act_station) && $stable(act_hash));
  endproperty
  AST_CFG_HELD_MID_FRAME: assert property (p_cfg_held); // R9
endmodule

// File: rtl/raf_crc_unit.sv
module raf_crc_unit
  import raf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        restart,
  input  logic [7:0]  din,
  output logic [31:0] crc_q,
  output logic [31:0] crc_next
);
  assign crc_next = crc_step_byte(restart ? CRC_SEED : crc_q, din);

  always_ff @(posedge clk) begin
    if (!rst_n)  crc_q <= CRC_SEED;
    else if (en) crc_q <= crc_next;
  end

  property p_crc_idle;
    @(posedge clk) disable iff (!rst_n) !en |=> $stable(crc_q);
  endproperty
  AST_CRC_HOLD_IN_GAP: assert property (p_crc_idle); // R11
endmodule

// File: rtl/raf_addr_capture.sv
module raf_addr_capture
  import raf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic        rx_sof,
  input  logic [7:0]  rx_byte,
  output logic        take,
  output logic        first,
  output logic        last,
  output logic [47:0] dest_now
);
  localparam logic [2:0] IDLE = 3'(ADDR_BYTES);

  logic [2:0]  cnt_q;
  logic [2:0]  pos;
  logic [47:0] addr_q;

  assign pos      = rx_sof ? 3'd0 : cnt_q;
  assign take     = rx_valid && (rx_sof || cnt_q != IDLE);
  assign first    = take && (pos == 3'd0);
  assign last     = take && (pos == IDLE - 3'd1);
  assign dest_now = {rx_byte, addr_q[39:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= IDLE;
      addr_q <= '0;
    end else if (take) begin
      addr_q[8*int'(pos) +: 8] <= rx_byte;
      cnt_q <= pos + 3'd1;
    end
  end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import raf_pkg::*;
#(
  parameter bit WIDE_HASH = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [3:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  input  logic        rx_valid,
  input  logic        rx_sof,
  input  logic [7:0]  rx_byte,
  output logic        dec_valid,
  output logic        dec_accept
);
  localparam int NWORDS = WIDE_HASH ? 8 : 2;
  localparam int HBITS  = NWORDS * 32;

  // named internal events
  logic             byte_take, first_byte, last_byte;
  logic [47:0]      dest_now, act_station;
  raf_ctrl_t        act_ctrl;
  logic [HBITS-1:0] act_hash;
  logic [31:0]      crc_q, crc_next;
  logic [7:0]       hidx;
  logic [31:0]      hash_word;
  logic             is_group, is_bcast, sta_hit, hash_hit, accept_now;

  raf_cfg_regs #(.NWORDS(NWORDS)) u_cfg (
    .clk, .rst_n, .wr_en(cfg_we), .wr_sel(cfg_sel), .wr_data(cfg_wdata),
    .snap(first_byte), .act_station, .act_ctrl, .act_hash
  );

  raf_addr_capture u_cap (
    .clk, .rst_n, .rx_valid, .rx_sof, .rx_byte,
    .take(byte_take), .first(first_byte), .last(last_byte), .dest_now
  );

  raf_crc_unit u_crc (
    .clk, .rst_n, .en(byte_take), .restart(first_byte), .din(rx_byte),
    .crc_q, .crc_next
  );

  assign hidx = hash_index(crc_next, WIDE_HASH);

  always_comb begin
    hash_word = '0;
    for (int k = 0; k < NWORDS; k++)
      if (hidx[7:5] == 3'(k)) hash_word = act_hash[k*32 +: 32];
  end

  assign hash_hit   = hash_word[hidx[4:0]];
  assign is_group   = dest_now[0];
  assign is_bcast   = &dest_now;
  assign sta_hit    = (dest_now == act_station);
  assign accept_now = act_ctrl.promisc || is_bcast || sta_hit ||
                      (is_group && (act_ctrl.all_grp || (act_ctrl.hash_en && hash_hit)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      dec_valid  <= last_byte;
      dec_accept <= last_byte && accept_now;
    end
  end

  AST_DEC_AFTER_SIXTH: assert property (@(posedge clk) disable iff (!rst_n) last_byte |=> dec_valid); // R2
  AST_NO_STRAY_DEC: assert property (@(posedge clk) disable iff (!rst_n) !last_byte |=> !dec_valid); // R2
  AST_PROMISC_TAKES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (last_byte && act_ctrl.promisc) |=> dec_accept); // R5
  AST_BCAST_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (last_byte && is_bcast) |=> dec_accept); // R4
  AST_UNICAST_MISS_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (last_byte && !act_ctrl.promisc && !is_group && !sta_hit) |=> !dec_accept); // R3
endmodule

// File: tb/test_rx_addr_filter.sv
`timescale 1ns/1ps
module test_rx_addr_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        rx_valid = 1'b0;
  logic        rx_sof = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        dec_valid, dec_accept;

  int checks = 0;
  int fails = 0;
  int frames = 0;
  int decs = 0;

  bit    exp_q[$];
  string tag_q[$];

  // bench shadow of the programmed registers
  logic [31:0] sh_lo = '0, sh_hi = '0, sh_ctrl = '0;
  logic [31:0] sh_hash [2] = '{default: '0};

  always #2.5 clk = ~clk;

  rx_addr_filter i_rx_addr_filter (
    .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_wdata,
    .rx_valid, .rx_sof, .rx_byte, .dec_valid, .dec_accept
  );

  function automatic logic [47:0] mac(input logic [7:0] b0, b1, b2, b3, b4, b5);
    return {b5, b4, b3, b2, b1, b0};
  endfunction

  // bit-serial CRC over the 48 address bits, LSB first
  function automatic logic [5:0] ref_index(input logic [47:0] a);
    logic [31:0] c;
    logic [7:0]  low, r;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < 48; i++) begin
      bit fb;
      fb = c[0] ^ a[i];
      c = c >> 1;
      if (fb) c = c ^ 32'hEDB8_8320;
    end
    low = ~c[7:0];
    for (int i = 0; i < 8; i++) r[7-i] = low[i];
    return r[7:2];
  endfunction

  function automatic bit model(input logic [47:0] a);
    logic [5:0] ix;
    bit grp, bc, hit, hh;
    ix  = ref_index(a);
    grp = a[0];
    bc  = (a == 48'hFFFF_FFFF_FFFF);
    hit = (a == {sh_hi[15:0], sh_lo});
    hh  = sh_hash[ix[5]][ix[4:0]];
    return sh_ctrl[0] || bc || hit || (grp && (sh_ctrl[1] || (sh_ctrl[2] && hh)));
  endfunction

  task automatic shadow(input logic [3:0] s, input logic [31:0] d);
    case (s)
      4'd0: sh_lo = d;
      4'd1: sh_hi = {16'd0, d[15:0]};
      4'd2: sh_ctrl = {29'd0, d[2:0]};
      4'd8: sh_hash[0] = d;
      4'd9: sh_hash[1] = d;
      default: ;
    endcase
  endtask

  task automatic wr(input logic [3:0] s, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    shadow(s, d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input logic [47:0] a, input string tag, input bit gap = 0,
                      input bit mid = 0, input logic [3:0] msel = 0,
                      input logic [31:0] mdata = 0, input int tail = 0);
    exp_q.push_back(model(a));
    tag_q.push_back(tag);
    frames++;
    for (int k = 0; k < 6; k++) begin
      if (gap && (k == 3 || k == 5)) begin
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_byte = 8'h5A; cfg_we = 1'b0;
      end
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = (k == 0); rx_byte = a[8*k +: 8]; cfg_we = 1'b0;
      if (mid && k == 3) begin
        cfg_we = 1'b1; cfg_sel = msel; cfg_wdata = mdata;
        shadow(msel, mdata);
      end
    end
    for (int t = 0; t < tail; t++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = 1'b0; rx_byte = 8'hFF; cfg_we = 1'b0;
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; cfg_we = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic partial(input logic [47:0] a, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = (k == 0); rx_byte = a[8*k +: 8];
    end
  endtask

  task automatic check(input bit ok, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, expv);
    end
  endtask

  // monitor: pops the scoreboard on every decision
  initial begin
    bit    e;
    string t;
    forever begin
      @(negedge clk);
      if (rst_n && dec_valid) begin
        decs++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 decision with no address pending", 1, 0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(dec_accept === e, t, int'(dec_accept), int'(e));
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  localparam logic [47:0] STA = 48'h5544_3322_1102;  // 02:11:22:33:44:55
  localparam logic [47:0] BC  = 48'hFFFF_FFFF_FFFF;

  initial begin
    logic [47:0] g1, g2, g3, u1;
    logic [5:0]  ix;
    g1 = mac(8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'h01);
    g2 = mac(8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'hFB);
    g3 = mac(8'h33, 8'h33, 8'h00, 8'h00, 8'h00, 8'h01);
    u1 = mac(8'h04, 8'h10, 8'h20, 8'h30, 8'h40, 8'h50);

    repeat (4) @(negedge clk);
    check(dec_valid === 1'b0 && dec_accept === 1'b0, "R1 outputs in reset", int'(dec_valid), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(dec_valid === 1'b0, "R1 idle after reset", int'(dec_valid), 0);
    send(STA, "R1 zero station, zero control drops station frame");

    wr(4'd0, 32'h3322_1102);
    wr(4'd1, 32'h0000_5544);
    send(STA, "R3 exact station match accepted");
    send(STA ^ 48'h0100_0000_0000, "R3 last byte differs dropped");
    send(STA ^ 48'h0000_0000_0004, "R3 first byte differs dropped");
    send(BC, "R4 broadcast with control clear");
    send(g1, "R8 group dropped with control clear");

    wr(4'd2, 32'h2);
    send(g1, "R6 pass-all-group accepts group");
    send(u1, "R6 pass-all-group leaves unicast dropped");

    wr(4'd2, 32'h1);
    send(u1, "R5 promiscuous accepts unicast");
    send(g3, "R5 promiscuous accepts group");

    wr(4'd2, 32'h4);
    send(g1, "R7 empty hash drops group");
    ix = ref_index(g1);
    wr(4'(8 + ix[5]), 32'd1 << ix[4:0]);
    send(g1, "R7 hash bit of g1 admits it");
    send(g2, "R7 other group per hash model");
    wr(4'd8, 32'hFFFF_FFFF);
    wr(4'd9, 32'hFFFF_FFFF);
    send(u1, "R7 full hash never admits unicast");
    send(g3, "R7 full hash admits group");
    wr(4'd8, 32'h0);
    wr(4'd9, 32'h0);
    send(g3, "R7 cleared hash drops group");

    wr(4'd2, 32'h0);
    send(g2, "R9 mid-frame write does not affect this frame", 0, 1, 4'd2, 32'h2);
    send(g2, "R9 mid-frame write applies to next frame");
    send(g2, "R9 mid-frame clear ignored until next frame", 0, 1, 4'd2, 32'h0);
    send(g2, "R9 cleared control now drops group");

    partial(BC, 3);
    send(STA ^ 48'h0000_0000_0100, "R10 restart after abandoned broadcast");
    send(STA, "R11 gaps inside address accepted", 1);
    send(u1, "R11 gaps inside non-matching address dropped", 1);
    send(STA, "R2 trailing bytes after address", 0, 0, 4'd0, 32'd0, 9);

    repeat (5) @(negedge clk);
    check(decs == frames, "R2 one decision per address (R10 partial gives none)", decs, frames);
    check(exp_q.size() == 0, "R2 no decision outstanding", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule